// File: doc/BRIEF.md
# Lockable Low-Memory Boundary Decoder

This block holds one 32-bit configuration register that marks the top of usable low DRAM on a 1 MB grid. It uses that boundary to route every incoming 32-bit address to one of four targets: ordinary DRAM, the graphics-stolen carve-out, the protected-segment carve-out, or not-DRAM. The two carve-outs sit directly under the boundary. The graphics-stolen region lies on top and takes in both the graphics data memory and the translation-table memory. The protected segment sits directly below it. Each carve-out size comes from a 2-bit select input.

The register has a lock bit of its own. A lock state machine with two states, `LK_OPEN` and `LK_SEALED`, guards it. The `SEAL` transition from `LK_OPEN` to `LK_SEALED` fires on an accepted write that sets the lock bit. `LK_SEALED` keeps itself (`HOLD`) until reset, and reset is the only way back to `LK_OPEN`. While the trusted-mode input is high, every write is refused, whatever the state.

The decode result is registered, so it appears one clock after the address is presented.

Top module: `lowmem_decoder`

## Requirements
- R1: The register layout is as follows. Bits 31:20 hold the boundary in 1 MB units, bits 19:1 always read zero, and bit 0 is the lock bit. `cfg_rdata` shows the register while `cfg_sel` is high and reads zero otherwise.
- R2: After reset the register reads 0x0010_0000, and the lock state is `LK_OPEN`.
- R3: An accepted write with bit 0 set takes the `SEAL` transition to `LK_SEALED`. The boundary is updated by that same write. From then on no write changes any bit, the lock bit included, until reset.
- R4: A write is accepted when `cfg_sel` and `cfg_we` are both high. The byte enables act as follows: `cfg_be[3]` writes bits 31:24, `cfg_be[2]` writes bits 23:20, and `cfg_be[0]` writes bit 0. `cfg_be[1]` has no effect, and data on reserved bits is ignored.
- R5: An address goes to DRAM only when it is strictly below the boundary, with boundary bits 19:0 taken as zero, and only when it is below both carve-out bases.
- R6: While `trusted_mode` is high, no write changes the register, whether it is locked or not.
- R7: The decode output is registered with one cycle of latency. When `out_valid` is high, `target` is one-hot, with bit 0 DRAM, bit 1 graphics-stolen, bit 2 protected segment and bit 3 not-DRAM. When `out_valid` is low, `target` is zero.
- R8: A boundary field of 0x000 is decoded as 1 MB.
- R9: The graphics-stolen base is the boundary minus the data size minus the table size. Addresses from that base up to the boundary go to the graphics-stolen target. The data select codes are 00=0, 01=1 MB, 10=32 MB, 11=64 MB. The table select codes are 00=0, 01=1 MB, 10=2 MB, 11=2 MB.
- R10: The protected-segment base is the graphics-stolen base minus the segment size. Addresses from that base up to the graphics-stolen base go to the protected-segment target. The select codes are 00=0, 01=1 MB, 10=2 MB, 11=8 MB.
- R11: A size of zero leaves the bases below it unchanged. A base that would fall below address 0 saturates at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_sel | input | 1 | Register offset match |
| cfg_we | input | 1 | Write strobe |
| cfg_be | input | 4 | Byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data |
| trusted_mode | input | 1 | Trusted mode: refuses all writes |
| gfx_data_sel | input | 2 | Graphics data memory size code |
| gfx_tbl_sel | input | 2 | Translation-table memory size code |
| pseg_sel | input | 2 | Protected segment size code |
| in_valid | input | 1 | Address valid |
| addr_in | input | 32 | Address to classify |
| out_valid | output | 1 | Result valid |
| target | output | 4 | One-hot target |

## Verification
The checker holds several rules on every cycle:
- the register stays frozen once sealed, and stays frozen while trusted mode is high;
- the target is one-hot whenever it is valid;
- the reserved bits read zero;
- nothing at or above a nonzero boundary is sent to DRAM.

The bench scenarios cover what the checker cannot:
- the exact base arithmetic for each size code, and saturation at address 0;
- the byte-lane merging;
- the reset value and the 1 MB floor for a zero boundary;
- the fact that only reset clears the lock.

// File: rtl/lmd_pkg.sv
package lmd_pkg;

    typedef enum logic [0:0] {
        LK_OPEN   = 1'b0,
        LK_SEALED = 1'b1
    } lock_state_e;

    typedef enum logic [1:0] {
        TGT_DRAM = 2'd0,
        TGT_GFX  = 2'd1,
        TGT_PSEG = 2'd2,
        TGT_NONE = 2'd3
    } target_e;

    // carve-out sizes in 1 MB units
    function automatic logic [7:0] gfx_data_mb(input logic [1:0] code);
        unique case (code)
            2'b00: return 8'd0;
            2'b01: return 8'd1;
            2'b10: return 8'd32;
            default: return 8'd64;
        endcase
    endfunction

    function automatic logic [7:0] gfx_tbl_mb(input logic [1:0] code);
        unique case (code)
            2'b00: return 8'd0;
            2'b01: return 8'd1;
            default: return 8'd2;
        endcase
    endfunction

    function automatic logic [7:0] pseg_mb(input logic [1:0] code);
        unique case (code)
            2'b00: return 8'd0;
            2'b01: return 8'd1;
            2'b10: return 8'd2;
            default: return 8'd8;
        endcase
    endfunction

endpackage

// File: rtl/lmd_cfg_reg.sv
module lmd_cfg_reg
    import lmd_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int FIELD_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sel,
    input  logic                we,
    input  logic [DATA_W/8-1:0] be,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                trusted,
    output logic [DATA_W-1:0]   rdata,
    output logic [FIELD_W-1:0]  bound,
    output logic                locked
);
    localparam int LANES = DATA_W / 8;
    localparam int RSV_W = DATA_W - FIELD_W - 1;
    localparam logic [DATA_W-1:0] WRITABLE = {{FIELD_W{1'b1}}, {RSV_W{1'b0}}, 1'b1};

    lock_state_e         state_q, state_d;
    logic [DATA_W-1:0]   lane_mask;
    logic [DATA_W-1:0]   wmask;
    logic                wr_ok;
    logic [FIELD_W-1:0]  bound_q;

    // expand byte enables into bit lanes
    for (genvar b = 0; b < LANES; b++) begin : g_lane
        assign lane_mask[b*8 +: 8] = {8{be[b]}};
    end

    assign wmask = lane_mask & WRITABLE;
    assign wr_ok = sel && we && !trusted && (state_q == LK_OPEN);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN:   if (wr_ok && wmask[0] && wdata[0]) state_d = LK_SEALED;
            LK_SEALED: state_d = LK_SEALED;
            default:   state_d = LK_OPEN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_d;
    end

    // boundary field register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bound_q <= FIELD_W'(1);
        end else if (wr_ok) begin
            bound_q <= (bound_q & ~wmask[DATA_W-1 -: FIELD_W])
                     | (wdata[DATA_W-1 -: FIELD_W] & wmask[DATA_W-1 -: FIELD_W]);
        end
    end

    // outputs
    always_comb begin
        locked = (state_q == LK_SEALED);
        bound  = bound_q;
        rdata  = sel ? {bound_q, {RSV_W{1'b0}}, locked} : '0;
    end

endmodule

// File: rtl/lmd_carve.sv
module lmd_carve
    import lmd_pkg::*;
#(
    parameter int FIELD_W = 12
) (
    input  logic [FIELD_W-1:0] bound,
    input  logic [1:0]         gfx_data_sel,
    input  logic [1:0]         gfx_tbl_sel,
    input  logic [1:0]         pseg_sel,
    output logic [FIELD_W-1:0] top_eff,
    output logic [FIELD_W-1:0] gfx_base,
    output logic [FIELD_W-1:0] pseg_base
);
    localparam int EXT_W = FIELD_W + 2;

    logic [EXT_W-1:0] top_x, gfx_sz, pseg_sz, gfx_x, pseg_x;

    always_comb begin
        top_x   = (bound == '0) ? EXT_W'(1) : EXT_W'(bound);
        gfx_sz  = EXT_W'(gfx_data_mb(gfx_data_sel)) + EXT_W'(gfx_tbl_mb(gfx_tbl_sel));
        pseg_sz = EXT_W'(pseg_mb(pseg_sel));
        gfx_x   = (gfx_sz > top_x) ? '0 : top_x - gfx_sz;
        pseg_x  = (pseg_sz > gfx_x) ? '0 : gfx_x - pseg_sz;
        top_eff   = top_x[FIELD_W-1:0];
        gfx_base  = gfx_x[FIELD_W-1:0];
        pseg_base = pseg_x[FIELD_W-1:0];
    end

endmodule

// File: rtl/lmd_addr_decode.sv
module lmd_addr_decode
    import lmd_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int FIELD_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [FIELD_W-1:0] top_eff,
    input  logic [FIELD_W-1:0] gfx_base,
    input  logic [FIELD_W-1:0] pseg_base,
    output logic               out_valid,
    output logic [3:0]         target
);
    logic [FIELD_W-1:0] page;
    target_e            sel_d;
    logic [3:0]         onehot_d;

    assign page = addr[ADDR_W-1 -: FIELD_W];

    always_comb begin
        if (page >= top_eff)        sel_d = TGT_NONE;
        else if (page >= gfx_base)  sel_d = TGT_GFX;
        else if (page >= pseg_base) sel_d = TGT_PSEG;
        else                        sel_d = TGT_DRAM;
        onehot_d = 4'b0001 << sel_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            target    <= '0;
        end else begin
            out_valid <= in_valid;
            target    <= in_valid ? onehot_d : '0;
        end
    end

endmodule

// File: rtl/lowmem_decoder.sv
module lowmem_decoder
    import lmd_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int GRAN_W  = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_sel,
    input  logic        cfg_we,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    input  logic        trusted_mode,
    input  logic [1:0]  gfx_data_sel,
    input  logic [1:0]  gfx_tbl_sel,
    input  logic [1:0]  pseg_sel,
    input  logic        in_valid,
    input  logic [31:0] addr_in,
    output logic        out_valid,
    output logic [3:0]  target
);
    localparam int FIELD_W = ADDR_W - GRAN_W;

    logic [FIELD_W-1:0] bound_q;
    logic               lock_q;
    logic [FIELD_W-1:0] top_eff, gfx_base, pseg_base;

    lmd_cfg_reg #(.DATA_W(ADDR_W), .FIELD_W(FIELD_W)) u_reg (
        .clk(clk), .rst_n(rst_n), .sel(cfg_sel), .we(cfg_we), .be(cfg_be),
        .wdata(cfg_wdata), .trusted(trusted_mode), .rdata(cfg_rdata),
        .bound(bound_q), .locked(lock_q)
    );

    lmd_carve #(.FIELD_W(FIELD_W)) u_carve (
        .bound(bound_q), .gfx_data_sel(gfx_data_sel), .gfx_tbl_sel(gfx_tbl_sel),
        .pseg_sel(pseg_sel), .top_eff(top_eff), .gfx_base(gfx_base),
        .pseg_base(pseg_base)
    );

    lmd_addr_decode #(.ADDR_W(ADDR_W), .FIELD_W(FIELD_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .addr(addr_in),
        .top_eff(top_eff), .gfx_base(gfx_base), .pseg_base(pseg_base),
        .out_valid(out_valid), .target(target)
    );

endmodule

// File: rtl/lowmem_decoder_chk.sv
module lowmem_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_sel,
    input logic [31:0] cfg_rdata,
    input logic        trusted_mode,
    input logic        in_valid,
    input logic [31:0] addr_in,
    input logic        out_valid,
    input logic [3:0]  target,
    input logic [11:0] bound_q,
    input logic        lock_q
);
    assert_lock_freeze_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> (lock_q && $stable(bound_q)));

    assert_trusted_freeze_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trusted_mode |=> ($stable(bound_q) && $stable(lock_q)));

    assert_target_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ($countones(target) == 1));

    assert_idle_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (target == 4'b0000));

    assert_no_dram_above_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && bound_q != 12'h000 && addr_in[31:20] >= bound_q) |=> !target[0]);

    always @(negedge clk) begin
        if (rst_n && cfg_sel)
            assert_reserved_zero_R1: assert (cfg_rdata[19:1] == 19'h0);
    end
endmodule

bind lowmem_decoder lowmem_decoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_rdata(cfg_rdata),
    .trusted_mode(trusted_mode), .in_valid(in_valid), .addr_in(addr_in),
    .out_valid(out_valid), .target(target), .bound_q(bound_q), .lock_q(lock_q)
);

// File: tb/lowmem_decoder_test.sv
module lowmem_decoder_test;

    typedef struct packed {
        logic [1:0]  gd;
        logic [1:0]  gt;
        logic [1:0]  ps;
        logic [31:0] addr;
        logic [3:0]  exp;
    } vec_t;

    // boundary fixed at 0xC00 (3072 MB) for the table
    localparam vec_t VECS [12] = '{
        '{2'b10, 2'b10, 2'b01, 32'h0000_0000, 4'b0001}, // R5 low DRAM
        '{2'b10, 2'b10, 2'b01, 32'hBFFF_FFFF, 4'b0010}, // R9 top of gfx
        '{2'b10, 2'b10, 2'b01, 32'hC000_0000, 4'b1000}, // R5 at boundary
        '{2'b10, 2'b10, 2'b01, 32'hBDE0_0000, 4'b0010}, // R9 gfx base 3038
        '{2'b10, 2'b10, 2'b01, 32'hBDDF_FFFF, 4'b0100}, // R10 pseg 3037
        '{2'b10, 2'b10, 2'b01, 32'hBDCF_FFFF, 4'b0001}, // R10 below pseg
        '{2'b10, 2'b10, 2'b01, 32'hFFFF_FFFF, 4'b1000}, // R5 top of space
        '{2'b00, 2'b00, 2'b00, 32'hBFFF_FFFF, 4'b0001}, // R11 all off
        '{2'b00, 2'b00, 2'b11, 32'hBF80_0000, 4'b0100}, // R10 8MB base 3064
        '{2'b00, 2'b00, 2'b11, 32'hBF7F_FFFF, 4'b0001}, // R11 gfx off
        '{2'b11, 2'b01, 2'b00, 32'hBBF0_0000, 4'b0010}, // R9 65MB base 3007
        '{2'b11, 2'b01, 2'b00, 32'hBBEF_FFFF, 4'b0001}  // R11 pseg off
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_sel = 1'b0, cfg_we = 1'b0, trusted_mode = 1'b0, in_valid = 1'b0;
    logic [3:0]  cfg_be = 4'h0;
    logic [31:0] cfg_wdata = 32'h0, addr_in = 32'h0;
    logic [1:0]  gfx_data_sel = 2'b00, gfx_tbl_sel = 2'b00, pseg_sel = 2'b00;
    logic [31:0] cfg_rdata;
    logic        out_valid;
    logic [3:0]  target;

    int n_checks = 0;
    int n_fail = 0;

    always #10 clk = ~clk;   // 50 MHz

    lowmem_decoder uut (
        .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_we(cfg_we),
        .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .trusted_mode(trusted_mode), .gfx_data_sel(gfx_data_sel),
        .gfx_tbl_sel(gfx_tbl_sel), .pseg_sel(pseg_sel), .in_valid(in_valid),
        .addr_in(addr_in), .out_valid(out_valid), .target(target)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        cfg_sel = 1'b1; cfg_we = 1'b1; cfg_be = be; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_be = 4'h0;
    endtask

    task automatic rd_check(input string req, input logic [31:0] exp);
        cfg_sel = 1'b1;
        #1 check(req, cfg_rdata, exp);
    endtask

    task automatic dec(input logic [31:0] a, input logic [3:0] exp, input string req);
        @(negedge clk);
        addr_in = a; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, {27'h0, out_valid, target}, {27'h0, 1'b1, exp});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        do_reset();
        rd_check("R2 reset value", 32'h0010_0000);
        cfg_sel = 1'b0;
        #1 check("R1 unselected read zero", cfg_rdata, 32'h0);

        // idle decode output
        @(negedge clk);
        check("R7 idle target", {27'h0, out_valid, target}, 32'h0);

        wr(4'hF, 32'hC00F_FFFE);
        rd_check("R4 reserved ignored", 32'hC000_0000);

        for (int i = 0; i < 12; i++) begin
            gfx_data_sel = VECS[i].gd; gfx_tbl_sel = VECS[i].gt; pseg_sel = VECS[i].ps;
            dec(VECS[i].addr, VECS[i].exp, $sformatf("R5/R9/R10/R11 vector %0d", i));
        end

        // byte lanes: only bits 23:20 from lane 2
        wr(4'b0100, 32'hFFAF_FFFF);
        rd_check("R4 lane2 only", 32'hC0A0_0000);
        wr(4'b0010, 32'hFFFF_FFFF);
        rd_check("R4 lane1 no effect", 32'hC0A0_0000);

        // trusted mode refuses writes
        trusted_mode = 1'b1;
        wr(4'hF, 32'h8000_0001);
        trusted_mode = 1'b0;
        rd_check("R6 trusted blocks", 32'hC0A0_0000);

        // zero boundary decodes as 1 MB
        gfx_data_sel = 2'b00; gfx_tbl_sel = 2'b00; pseg_sel = 2'b00;
        wr(4'hF, 32'h0000_0000);
        rd_check("R8 zero field stored", 32'h0000_0000);
        dec(32'h000F_FFFF, 4'b0001, "R8 below 1MB is DRAM");
        dec(32'h0010_0000, 4'b1000, "R8 at 1MB not DRAM");

        // saturation at zero
        wr(4'hF, 32'h0020_0000);
        gfx_data_sel = 2'b11;
        dec(32'h0000_0000, 4'b0010, "R11 base saturates");
        gfx_data_sel = 2'b00;

        // lock seals in the same write
        wr(4'hF, 32'hC000_0001);
        rd_check("R3 seal write", 32'hC000_0001);
        wr(4'hF, 32'h4000_0000);
        rd_check("R3 locked unchanged", 32'hC000_0001);
        dec(32'hBFFF_FFFF, 4'b0001, "R5 locked boundary decodes");
        do_reset();
        rd_check("R3 reset clears lock", 32'h0010_0000);
        wr(4'hF, 32'h4000_0000);
        rd_check("R3 writable after reset", 32'h4000_0000);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule